// File: doc/BRIEF.md
# Serial Flash Command and Program Engine

This block sits behind an SPI slave front-end and interprets the byte stream of one chip-select frame as a flash command. The front-end hands over each received byte with a one-cycle strobe and marks the rising edge of chip-select with a frame-end pulse. The block models a byte-wide flash array that powers up erased to all ones. It handles the write-enable latch, page programming, sector and bulk erase, array reads and a small status register. Two protect bits in that status register fence off part of the array, and a write-protect pin can freeze those bits.

Program and erase only take effect when the frame closes with the correct byte count and the write-enable latch is set. Programming can only clear bits. Each accepted program or erase then runs as a busy phase. In that phase the engine walks the affected bytes one per cycle, then counts a fixed number of extra cycles. Reading the status register is the only command served while the engine is busy. The default geometry is a 2 KiB array in two sectors of 128-byte pages. Setting `ADDR_W` to 16 gives a 64 KiB array of two sectors of 256 pages.

Top module: `sfe_top`

## Requirements
- R1: After reset, busy_o is 0, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Opcode 0x05 returns the status byte for every byte after the opcode. The status byte holds busy in bit 0, the write-enable latch in bit 1, the protect bits in bits 3:2 and zeros elsewhere. The command is served even while busy.
- R3: Opcode 0x03 is followed by three address bytes, most significant byte first; only the low ADDR_W bits are used. Each further byte returns the next array byte and wraps from the last address to 0. A response pulses resp_valid_o in the cycle after the byte strobe that caused it.
- R4: Opcode 0x06 in a frame of exactly one byte sets the write-enable latch. Opcodes 0x02, 0xD8, 0xC7 and 0x01 have no effect on the array or the status byte while the latch is clear.
- R5: Opcode 0x02 with three address bytes and at least one data byte programs the page that holds the address. Each stored byte becomes the old value AND the new value.
- R6: Program data starts at the address offset within its page and wraps to the page start. When more than one page of data is sent, only the last 128 bytes take effect.
- R7: Opcode 0xD8 in a frame of exactly 4 bytes erases the half of the array (sector) holding the address to 0xFF and leaves the other sector unchanged. Opcode 0xC7 in a frame of exactly one byte erases the whole array.
- R8: A command takes effect only when frame_end_i closes a frame of its exact length (at least 5 bytes for 0x02). A frame of any other length changes nothing, including the latch. An accepted 0x02, 0xD8, 0xC7 or 0x01 clears the latch, even when protection rejects it.
- R9: busy_o rises the cycle after the closing frame_end_i. It stays high for exactly N + BUSY_CYC cycles, where N is 128 for a page program, the sector size for a sector erase and the array size for a bulk erase.
- R10: While busy, a frame whose opcode is not 0x05 produces no response and changes no state.
- R11: Protect code 00 protects nothing, 01 protects the upper sector and 1x protects the whole array. A program or sector erase in a protected area, and a bulk erase with a nonzero code, leave the array unchanged and do not raise busy_o.
- R12: Opcode 0x01 in a frame of exactly 2 bytes copies bits 3:2 of the data byte into the protect bits unless wp_i is high, in which case the protect bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | One-cycle strobe for a received byte |
| byte_i | input | 8 | Received byte |
| frame_end_i | input | 1 | One-cycle pulse when chip-select rises |
| wp_i | input | 1 | High freezes the protect bits |
| resp_valid_o | output | 1 | Response byte valid |
| resp_o | output | 8 | Response byte to shift out |
| busy_o | output | 1 | Program or erase in progress |

## Verification
The hardest case to reach is a page program that runs past its page: the data must wrap and the overwritten offsets must keep only the last value sent. The bench sends 130 bytes from offset 0, then a short burst from near the end of another page, and reads both pages back. A second hard case is a command that arrives while the engine is busy. The bench sends reads, write-enables and status reads in the cycles right after a program commit. It then checks that only the status frames answered and that the latch stayed clear once busy dropped.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  typedef enum logic [1:0] {JOB_PP, JOB_SE, JOB_BE} job_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WORK, ST_WAIT} eng_st_e;
endpackage

// File: rtl/sfe_frame.sv
module sfe_frame #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              frame_end_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [7:0]        op_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      op_o   <= '0;
      addr_o <= '0;
    end else if (frame_end_i) begin
      cnt_o <= '0;
    end else if (byte_valid_i) begin
      if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (cnt_o == '0) op_o <= byte_i;
      if (cnt_o >= CNT_W'(1) && cnt_o <= CNT_W'(3))
        addr_o <= {addr_o[ADDR_W-9:0], byte_i};
    end
  end
endmodule

// File: rtl/sfe_page_buf.sv
module sfe_page_buf #(
  parameter int PAGE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [PAGE_W-1:0] widx_i,
  input  logic [7:0]        wdata_i,
  input  logic [PAGE_W-1:0] ridx_i,
  output logic [7:0]        rdata_o
);
  localparam int PAGE = 1 << PAGE_W;
  logic [7:0] pg_q [PAGE];

  // preset to all ones: untouched offsets leave the array unchanged
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < PAGE; i++) pg_q[i] <= 8'hFF;
    end else if (clear_i) begin
      for (int i = 0; i < PAGE; i++) pg_q[i] <= 8'hFF;
    end else if (wr_i) begin
      pg_q[widx_i] <= wdata_i;
    end
  end

  assign rdata_o = pg_q[ridx_i];
endmodule

// File: rtl/sfe_array.sv
module sfe_array
  import sfe_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 7,
  parameter int BUSY_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  job_e              job_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [7:0]        pb_data_i,
  output logic [PAGE_W-1:0] pb_idx_o,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o,
  output logic              busy_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int WCW   = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
  localparam logic [ADDR_W-1:0] PAGE_M1 = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] SECT_M1 = ADDR_W'((DEPTH / 2) - 1);
  localparam logic [ADDR_W-1:0] ALL_M1  = ADDR_W'(DEPTH - 1);
  localparam logic [WCW-1:0]    WAIT_M1 = WCW'((BUSY_CYC > 0) ? BUSY_CYC - 1 : 0);

  logic [7:0]        mem_q [DEPTH];
  eng_st_e           st_q;
  job_e              job_q;
  logic [ADDR_W-1:0] cur_q, rem_q;
  logic [WCW-1:0]    wcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      st_q   <= ST_IDLE;
      job_q  <= JOB_PP;
      cur_q  <= '0;
      rem_q  <= '0;
      wcnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_WORK;
          job_q <= job_i;
          cur_q <= base_i;
          rem_q <= (job_i == JOB_PP) ? PAGE_M1 : (job_i == JOB_SE) ? SECT_M1 : ALL_M1;
        end
        ST_WORK: begin
          mem_q[cur_q] <= (job_q == JOB_PP) ? (mem_q[cur_q] & pb_data_i) : 8'hFF;
          cur_q <= cur_q + 1'b1;
          rem_q <= rem_q - 1'b1;
          if (rem_q == '0) begin
            st_q   <= (BUSY_CYC > 0) ? ST_WAIT : ST_IDLE;
            wcnt_q <= WAIT_M1;
          end
        end
        ST_WAIT: begin
          wcnt_q <= wcnt_q - 1'b1;
          if (wcnt_q == '0) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign pb_idx_o = cur_q[PAGE_W-1:0];
  assign rdata_o  = mem_q[raddr_i];
  assign busy_o   = (st_q != ST_IDLE);

  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> st_q == ST_IDLE); // R10
  AST_BUSY_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o); // R9
endmodule

// File: rtl/sfe_top.sv
module sfe_top
  import sfe_pkg::*;
#(
  parameter int ADDR_W   = 11,
  parameter int PAGE_W   = 7,
  parameter int BUSY_CYC = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       byte_valid_i,
  input  logic [7:0] byte_i,
  input  logic       frame_end_i,
  input  logic       wp_i,
  output logic       resp_valid_o,
  output logic [7:0] resp_o,
  output logic       busy_o
);
  localparam int CNT_W = 8;

  logic [CNT_W-1:0]  cnt;
  logic [7:0]        op;
  logic [ADDR_W-1:0] addr, addr_now, rd_ptr_q, commit_base;
  logic [PAGE_W-1:0] pb_ptr_q, pb_ridx;
  logic [7:0]        pb_rdata, arr_rdata, status;
  logic [1:0]        bp_q, sr_data_q;
  logic              acc_q, wel_q, busy;
  logic              pb_wr, pb_clear, start, prot, closing;
  job_e              job;

  sfe_frame #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .byte_valid_i, .byte_i, .frame_end_i,
    .cnt_o(cnt), .op_o(op), .addr_o(addr)
  );

  assign addr_now = {addr[ADDR_W-9:0], byte_i};
  assign status   = {4'b0, bp_q, wel_q, busy};
  assign pb_wr    = byte_valid_i && acc_q && cnt >= CNT_W'(4) && op == OP_PP;
  assign pb_clear = byte_valid_i && cnt == '0 && byte_i == OP_PP && !busy;

  sfe_page_buf #(.PAGE_W(PAGE_W)) u_pbuf (
    .clk_i, .rst_ni, .clear_i(pb_clear), .wr_i(pb_wr), .widx_i(pb_ptr_q),
    .wdata_i(byte_i), .ridx_i(pb_ridx), .rdata_o(pb_rdata)
  );

  // commit decode at chip-select rise
  assign closing = frame_end_i && acc_q && wel_q;
  assign prot    = bp_q[1] || (bp_q[0] && addr[ADDR_W-1]);
  always_comb begin
    start       = 1'b0;
    job         = JOB_PP;
    commit_base = '0;
    if (closing) begin
      unique case (op)
        OP_PP: begin
          job         = JOB_PP;
          commit_base = {addr[ADDR_W-1:PAGE_W], PAGE_W'(0)};
          start       = cnt >= CNT_W'(5) && !prot;
        end
        OP_SE: begin
          job         = JOB_SE;
          commit_base = {addr[ADDR_W-1], (ADDR_W-1)'(0)};
          start       = cnt == CNT_W'(4) && !prot;
        end
        OP_BE: begin
          job   = JOB_BE;
          start = cnt == CNT_W'(1) && bp_q == 2'b00;
        end
        default: ;
      endcase
    end
  end

  sfe_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC)) u_array (
    .clk_i, .rst_ni, .start_i(start), .job_i(job), .base_i(commit_base),
    .pb_data_i(pb_rdata), .pb_idx_o(pb_ridx), .raddr_i(rd_ptr_q),
    .rdata_o(arr_rdata), .busy_o(busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q        <= 1'b0;
      wel_q        <= 1'b0;
      bp_q         <= 2'b00;
      sr_data_q    <= 2'b00;
      rd_ptr_q     <= '0;
      pb_ptr_q     <= '0;
      resp_valid_o <= 1'b0;
      resp_o       <= '0;
    end else begin
      resp_valid_o <= 1'b0;
      if (byte_valid_i) begin
        if (cnt == '0) begin
          acc_q <= !busy || byte_i == OP_RDSR;
        end else if (acc_q) begin
          unique case (op)
            OP_RDSR: begin
              resp_valid_o <= 1'b1;
              resp_o       <= status;
            end
            OP_READ: begin
              if (cnt == CNT_W'(3)) rd_ptr_q <= addr_now;
              if (cnt >= CNT_W'(4)) begin
                resp_valid_o <= 1'b1;
                resp_o       <= arr_rdata;
                rd_ptr_q     <= rd_ptr_q + 1'b1;
              end
            end
            OP_PP: begin
              if (cnt == CNT_W'(3)) pb_ptr_q <= byte_i[PAGE_W-1:0];
              if (cnt >= CNT_W'(4)) pb_ptr_q <= pb_ptr_q + 1'b1;
            end
            OP_WRSR: if (cnt == CNT_W'(1)) sr_data_q <= byte_i[3:2];
            default: ;
          endcase
        end
      end
      if (frame_end_i && acc_q) begin
        unique case (op)
          OP_WREN: if (cnt == CNT_W'(1)) wel_q <= 1'b1;
          OP_PP:   if (wel_q && cnt >= CNT_W'(5)) wel_q <= 1'b0;
          OP_SE:   if (wel_q && cnt == CNT_W'(4)) wel_q <= 1'b0;
          OP_BE:   if (wel_q && cnt == CNT_W'(1)) wel_q <= 1'b0;
          OP_WRSR: if (wel_q && cnt == CNT_W'(2)) begin
            wel_q <= 1'b0;
            if (!wp_i) bp_q <= sr_data_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o = busy;

  AST_NO_STROBE_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_i && frame_end_i)); // R8
  AST_WEL_DROPS_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !wel_q); // R8
  AST_BP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |=> $stable(bp_q)); // R12
  AST_RESP_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $past(byte_valid_i)); // R3
  AST_BUSY_ONLY_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && $past(busy) && $past(busy, 2)) |-> resp_o[0]); // R10
endmodule

// File: tb/sfe_top_bench.sv
module sfe_top_bench;
  localparam int ADDR_W   = 11;
  localparam int PAGE_W   = 7;
  localparam int BUSY_CYC = 16;
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE     = 1 << PAGE_W;
  localparam int SECT     = DEPTH / 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_valid = 1'b0, frame_end = 1'b0, wp = 1'b0;
  logic [7:0] byte_d = '0;
  logic resp_valid, busy;
  logic [7:0] resp;

  always #2 clk = ~clk;

  sfe_top #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BUSY_CYC(BUSY_CYC)) u_sfe_top (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_d),
    .frame_end_i(frame_end), .wp_i(wp), .resp_valid_o(resp_valid),
    .resp_o(resp), .busy_o(busy)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] pdata [256];
  logic       done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: pop and compare every response
  always @(negedge clk) begin
    if (rst_n && resp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", resp, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(resp == e, t, resp, e);
      end
    end
  end

  task automatic push(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic send(input logic [7:0] b);
    byte_valid = 1'b1;
    byte_d = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic end_frame();
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  task automatic send_addr(input int a);
    send(8'(a >> 16)); send(8'(a >> 8)); send(8'(a));
  endtask

  task automatic rdsr(input logic [7:0] e, input string t);
    send(8'h05); push(e, t); send(8'h00); push(e, t); send(8'h00); end_frame();
  endtask

  task automatic rd(input int a, input int n, input string t);
    send(8'h03); send_addr(a);
    for (int i = 0; i < n; i++) begin
      push(model[(a + i) % DEPTH], t);
      send(8'hFF);
    end
    end_frame();
  endtask

  task automatic wren(); send(8'h06); end_frame(); endtask

  task automatic pp(input int a, input int n);
    send(8'h02); send_addr(a);
    for (int i = 0; i < n; i++) send(pdata[i]);
    end_frame();
  endtask

  // expected effect of an accepted page program
  task automatic model_pp(input int a, input int n);
    logic [7:0] pg [PAGE];
    int base = a & ~(PAGE - 1);
    for (int i = 0; i < PAGE; i++) pg[i] = 8'hFF;
    for (int i = 0; i < n; i++) pg[(a + i) % PAGE] = pdata[i];
    for (int i = 0; i < PAGE; i++) model[base + i] = model[base + i] & pg[i];
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(resp_valid == 1'b0, "R1 no response after reset", resp_valid, 0);
    rdsr(8'h00, "R1 R2 status after reset");
    rd(0, 2, "R1 erased array");
    rd(DEPTH - 1, 2, "R3 read wraps at end of array");

    // R4 program without write enable is ignored
    pdata[0] = 8'h12;
    pp(16, 1);
    check(busy == 1'b0, "R4 no busy without latch", busy, 0);
    rd(16, 1, "R4 array untouched without latch");

    // R4 R2 latch set; R8 wrong length of WREN ignored
    send(8'h06); send(8'h00); end_frame();
    rdsr(8'h00, "R8 two-byte write enable ignored");
    wren();
    rdsr(8'h02, "R4 R2 latch set");

    // R5 R9 program with busy length
    pdata[0] = 8'hA5; pdata[1] = 8'h3C;
    pp(16, 2);
    model_pp(16, 2);
    begin
      int n = 0;
      while (busy && n < 100000) begin n++; @(negedge clk); end
      check(n == PAGE + BUSY_CYC, "R9 page program busy cycles", n, PAGE + BUSY_CYC);
    end
    rd(15, 4, "R5 program result");

    // R10 commands while busy
    wren();
    pdata[0] = 8'h0F;
    pp(16, 1);
    model_pp(16, 1);
    check(busy == 1'b1, "R9 busy raised after commit", busy, 1);
    rdsr(8'h01, "R2 R10 status while busy");
    send(8'h03); send_addr(0); send(8'hFF); send(8'hFF); end_frame();
    wren();
    wait_idle();
    rdsr(8'h00, "R10 write enable during busy ignored");
    rd(16, 2, "R5 AND with old value");

    // R6 wrap within page
    wren();
    pdata[0] = 8'h11; pdata[1] = 8'h22; pdata[2] = 8'h33;
    pp(PAGE + PAGE - 2, 3);
    model_pp(PAGE + PAGE - 2, 3);
    wait_idle();
    rd(PAGE, 2, "R6 wrap to page start");
    rd(2 * PAGE - 2, 3, "R6 tail of page");

    // R6 last 128 bytes kept
    wren();
    for (int i = 0; i < PAGE + 2; i++) pdata[i] = 8'(i);
    pp(2 * PAGE, PAGE + 2);
    model_pp(2 * PAGE, PAGE + 2);
    check(model[2 * PAGE] == 8'h80, "R6 bench model overwrite", model[2 * PAGE], 8'h80);
    wait_idle();
    rd(2 * PAGE, 4, "R6 last page of data kept");

    // data in upper sector
    wren();
    pdata[0] = 8'h5A;
    pp(SECT + 3, 1);
    model_pp(SECT + 3, 1);
    wait_idle();

    // R8 sector erase with wrong length ignored, latch kept
    wren();
    send(8'hD8); send(8'h00); send(8'h00); end_frame();
    check(busy == 1'b0, "R8 short erase ignored", busy, 0);
    rdsr(8'h02, "R8 latch kept after bad length");

    // R7 sector erase of sector 0
    send(8'hD8); send_addr(5); end_frame();
    for (int i = 0; i < SECT; i++) model[i] = 8'hFF;
    begin
      int n = 0;
      while (busy && n < 100000) begin n++; @(negedge clk); end
      check(n == SECT + BUSY_CYC, "R9 sector erase busy cycles", n, SECT + BUSY_CYC);
    end
    rd(14, 4, "R7 sector 0 erased");
    rd(SECT + 2, 3, "R7 sector 1 kept");

    // R12 R11 protect upper sector
    wren();
    send(8'h01); send(8'h04); end_frame();
    rdsr(8'h04, "R12 protect bits written");
    wren();
    pdata[0] = 8'h00;
    pp(SECT + 3, 1);
    check(busy == 1'b0, "R11 protected program rejected", busy, 0);
    rdsr(8'h04, "R8 latch cleared on rejected program");
    rd(SECT + 3, 1, "R11 protected byte kept");
    wren();
    send(8'hC7); end_frame();
    check(busy == 1'b0, "R11 bulk erase rejected", busy, 0);
    wren();
    pdata[0] = 8'h77;
    pp(20, 1);
    model_pp(20, 1);
    wait_idle();
    rd(20, 1, "R11 lower sector still writable");

    // R12 frozen by pin
    wp = 1'b1;
    wren();
    send(8'h01); send(8'h00); end_frame();
    rdsr(8'h04, "R12 protect bits frozen by pin");
    wp = 1'b0;
    wren();
    send(8'h01); send(8'h00); end_frame();
    rdsr(8'h00, "R12 protect bits cleared");

    // R7 bulk erase
    wren();
    send(8'hC7); end_frame();
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    begin
      int n = 0;
      while (busy && n < 100000) begin n++; @(negedge clk); end
      check(n == DEPTH + BUSY_CYC, "R9 bulk erase busy cycles", n, DEPTH + BUSY_CYC);
    end
    rd(20, 1, "R7 bulk erase lower");
    rd(SECT + 3, 1, "R7 bulk erase upper");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 missing responses", exp_q.size(), 0);
    done = 1'b1;
    finish_run();
  end
endmodule